// File: doc/BRIEF.md
# Segmented Operand Address Generator

This block forms the address of a memory operand for a real-mode machine that uses segments. Each request carries an addressing-mode code, the current value of a base register, the current value of an index register, a 16-bit displacement and a 16-bit segment value. The block combines the base, index and displacement into a 16-bit offset (the effective address), as the mode selects. It then relocates that offset into a 20-bit physical space by adding the segment value shifted left by four bits.

The block does not decode instructions and does not choose segments. Register and segment values arrive ready to use. A request is a one-cycle strobe. The result is registered and appears one clock later with a one-cycle valid pulse. There is no ready input and no back-pressure: the consumer must take every result in the cycle its valid is high. A new request may be given in every cycle. Between results, the outputs hold the last result.

Top module: `seg_addr_gen`

## Requirements
- R1: Mode code 3'd0 (direct) gives an effective address equal to the displacement.
- R2: Mode code 3'd1 (register indirect) gives an effective address equal to the base register input.
- R3: Mode code 3'd2 (based) gives an effective address of base plus displacement.
- R4: Mode code 3'd3 (indexed) gives an effective address of index plus displacement.
- R5: Mode code 3'd4 (based-indexed) gives an effective address of base plus index plus displacement.
- R6: The physical address is 16 times the segment value plus the effective address, kept to 20 bits. For example, segment 0100h with offset 0100h gives 01100h, and segment 1100h with offset 0101h gives 11101h.
- R7: Effective-address sums wrap modulo 2^16. Physical sums past 20 bits drop their carry.
- R8: Mode codes 5, 6 and 7 raise the error output and give zero for both addresses. Legal codes leave the error output low.
- R9: The valid output is high in exactly the cycle after a sampled request and low otherwise. Requests on consecutive cycles give consecutive results.
- R10: A synchronous reset clears valid, both addresses and the error output. A reset wins over a request in the same cycle.
- R11: In a cycle with no request, the address and error outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, sampled each edge |
| mode | input | 3 | Addressing-mode code |
| base_val | input | 16 | Base or pointer register value |
| index_val | input | 16 | Index register value |
| disp | input | 16 | Displacement |
| seg_val | input | 16 | Segment value |
| res_valid | output | 1 | One-cycle result strobe |
| res_ea | output | 16 | Effective address |
| res_phys | output | 20 | Physical address |
| res_err | output | 1 | Illegal mode code flag |

## Verification
Two events can fall in the same cycle: a new request can arrive while the previous result is being presented, and a request can coincide with a synchronous reset. The bench issues runs of back-to-back requests of mixed legal and illegal modes. It also holds the request high through reset and asserts reset in the middle of a stream. A behavioural model predicts valid, both addresses and the error flag for every cycle. The bench checks that each back-to-back result replaces its predecessor without a gap, and that reset suppresses the colliding request.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [2:0] {
    AM_DIRECT   = 3'd0,
    AM_PTR      = 3'd1,
    AM_BASED    = 3'd2,
    AM_INDEXED  = 3'd3,
    AM_BASE_IDX = 3'd4
  } amode_e;
endpackage

// File: rtl/sag_offset_unit.sv
module sag_offset_unit
  import seg_addr_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic [2:0]       mode,
  input  logic [OFS_W-1:0] base_val,
  input  logic [OFS_W-1:0] index_val,
  input  logic [OFS_W-1:0] disp,
  output logic [OFS_W-1:0] ea,
  output logic             bad_mode
);
  logic use_base, use_index, use_disp;

  always_comb begin
    use_base  = 1'b0;
    use_index = 1'b0;
    use_disp  = 1'b0;
    bad_mode  = 1'b0;
    case (mode)
      AM_DIRECT:   use_disp = 1'b1;
      AM_PTR:      use_base = 1'b1;
      AM_BASED:    begin use_base = 1'b1; use_disp = 1'b1; end
      AM_INDEXED:  begin use_index = 1'b1; use_disp = 1'b1; end
      AM_BASE_IDX: begin use_base = 1'b1; use_index = 1'b1; use_disp = 1'b1; end
      default:     bad_mode = 1'b1;
    endcase
  end

  // three-input sum, carry past OFS_W discarded
  always_comb begin
    ea = (use_base  ? base_val  : '0)
       + (use_index ? index_val : '0)
       + (use_disp  ? disp      : '0);
  end
endmodule

// File: rtl/sag_relocator.sv
module sag_relocator #(
  parameter int OFS_W     = 16,
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = SEG_W + SEG_SHIFT
) (
  input  logic [SEG_W-1:0]  seg_val,
  input  logic [OFS_W-1:0]  ea,
  output logic [PHYS_W-1:0] phys
);
  logic [PHYS_W-1:0] seg_shifted;
  logic [PHYS_W-1:0] ea_wide;

  assign seg_shifted = {seg_val, {SEG_SHIFT{1'b0}}};

  generate
    if (PHYS_W > OFS_W) begin : g_zext
      assign ea_wide = {{(PHYS_W-OFS_W){1'b0}}, ea};
    end else begin : g_trunc
      assign ea_wide = ea[PHYS_W-1:0];
    end
  endgenerate

  assign phys = seg_shifted + ea_wide;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int OFS_W     = 16,
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = SEG_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [2:0]        mode,
  input  logic [OFS_W-1:0]  base_val,
  input  logic [OFS_W-1:0]  index_val,
  input  logic [OFS_W-1:0]  disp,
  input  logic [SEG_W-1:0]  seg_val,
  output logic              res_valid,
  output logic [OFS_W-1:0]  res_ea,
  output logic [PHYS_W-1:0] res_phys,
  output logic              res_err
);
  logic [OFS_W-1:0]  ea_c;
  logic              bad_c;
  logic [PHYS_W-1:0] phys_c;

  sag_offset_unit #(.OFS_W(OFS_W)) u_ofs (
    .mode(mode), .base_val(base_val), .index_val(index_val), .disp(disp),
    .ea(ea_c), .bad_mode(bad_c)
  );

  sag_relocator #(.OFS_W(OFS_W), .SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT)) u_rel (
    .seg_val(seg_val), .ea(ea_c), .phys(phys_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_ea    <= '0;
      res_phys  <= '0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= req;
      if (req) begin
        res_err  <= bad_c;
        res_ea   <= bad_c ? '0 : ea_c;
        res_phys <= bad_c ? '0 : phys_c;
      end
    end
  end

  a_r9_valid_after_req: assert property (@(posedge clk) disable iff (rst)
    req |=> res_valid);
  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !req |=> !res_valid);
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!res_valid && res_ea == '0 && res_phys == '0 && !res_err));
  a_r8_err_zero_addr: assert property (@(posedge clk) disable iff (rst)
    res_err |-> (res_ea == '0 && res_phys == '0));
  a_r8_err_tracks_mode: assert property (@(posedge clk) disable iff (rst)
    req |=> (res_err == ($past(mode) > 3'd4)));
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !req |=> ($stable(res_ea) && $stable(res_phys) && $stable(res_err)));
endmodule

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [15:0] base_val = '0, index_val = '0, disp = '0, seg_val = '0;
  logic        res_valid;
  logic [15:0] res_ea;
  logic [19:0] res_phys;
  logic        res_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  seg_addr_gen u0 (
    .clk(clk), .rst(rst), .req(req), .mode(mode), .base_val(base_val),
    .index_val(index_val), .disp(disp), .seg_val(seg_val),
    .res_valid(res_valid), .res_ea(res_ea), .res_phys(res_phys), .res_err(res_err)
  );

  // behavioural reference model
  bit    m_valid = 0, m_err = 0;
  int    m_ea = 0, m_phys = 0;
  string m_tag = "R10";
  string m_ptag = "R10";

  always @(posedge clk) begin
    int sum;
    if (rst) begin
      m_valid = 0; m_err = 0; m_ea = 0; m_phys = 0; m_tag = "R10"; m_ptag = "R10";
    end else begin
      m_valid = req;
      if (req) begin
        m_err = 0;
        case (mode)
          3'd0: begin sum = int'(disp); m_tag = "R1"; end
          3'd1: begin sum = int'(base_val); m_tag = "R2"; end
          3'd2: begin sum = int'(base_val) + int'(disp); m_tag = "R3"; end
          3'd3: begin sum = int'(index_val) + int'(disp); m_tag = "R4"; end
          3'd4: begin sum = int'(base_val) + int'(index_val) + int'(disp); m_tag = "R5"; end
          default: begin sum = 0; m_err = 1; m_tag = "R8"; end
        endcase
        if (sum > 65535) m_tag = "R7";
        m_ea = sum % 65536;
        m_phys = m_err ? 0 : (int'(seg_val) * 16 + m_ea);
        m_ptag = (m_phys > 20'hFFFFF) ? "R7" : (m_err ? "R8" : "R6");
        m_phys = m_phys % (1 << 20);
      end else begin
        m_tag = "R11"; m_ptag = "R11";
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (res_valid !== m_valid) begin
        failures++;
        $display("FAIL R9 valid actual=%0b expected=%0b", res_valid, m_valid);
      end
      checks++;
      if (res_ea !== m_ea[15:0]) begin
        failures++;
        $display("FAIL %s ea actual=%h expected=%h", m_tag, res_ea, m_ea[15:0]);
      end
      checks++;
      if (res_phys !== m_phys[19:0]) begin
        failures++;
        $display("FAIL %s phys actual=%h expected=%h", m_ptag, res_phys, m_phys[19:0]);
      end
      checks++;
      if (res_err !== m_err) begin
        failures++;
        $display("FAIL R8 err actual=%0b expected=%0b", res_err, m_err);
      end
    end
  end

  task automatic issue(input logic [2:0] m, input logic [15:0] b, input logic [15:0] x,
                       input logic [15:0] d, input logic [15:0] s);
    @(negedge clk);
    req = 1'b1; mode = m; base_val = b; index_val = x; disp = d; seg_val = s;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = 1'b0;
      base_val = 16'hDEAD; disp = 16'hBEEF; mode = 3'd4;
    end
  endtask

  initial begin
    // R10: request held high during reset must be ignored
    req = 1'b1; mode = 3'd0; disp = 16'h5555;
    repeat (3) @(negedge clk);
    rst = 1'b0; req = 1'b0;
    idle(1);
    // R1, R6 worked examples
    issue(3'd0, 16'h0000, 16'h0000, 16'h0100, 16'h0100);
    issue(3'd0, 16'h0000, 16'h0000, 16'h0101, 16'h1100);
    idle(1);
    issue(3'd1, 16'h1234, 16'h9999, 16'h7777, 16'h2000);   // R2
    issue(3'd2, 16'h1000, 16'h9999, 16'h0234, 16'h1200);   // R3
    issue(3'd3, 16'h9999, 16'h0200, 16'h0030, 16'h3000);   // R4
    issue(3'd4, 16'h0100, 16'h0020, 16'h0003, 16'h4000);   // R5
    idle(2);                                               // R11 hold
    issue(3'd4, 16'hFFFF, 16'h0002, 16'h0001, 16'h0000);   // R7 ea wrap
    issue(3'd0, 16'h0000, 16'h0000, 16'h0020, 16'hFFFF);   // R7 phys wrap
    issue(3'd5, 16'h1111, 16'h2222, 16'h3333, 16'h4444);   // R8
    issue(3'd6, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    idle(1);
    issue(3'd7, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    issue(3'd2, 16'h0010, 16'h0000, 16'h0001, 16'h0001);   // back-to-back after error
    // reset in the middle of a request stream
    issue(3'd3, 16'h0000, 16'h0400, 16'h0004, 16'h0040);
    @(negedge clk); rst = 1'b1; req = 1'b1; mode = 3'd4;
    @(negedge clk); rst = 1'b0; req = 1'b0;
    idle(1);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[31:29] == 3'd0) idle(1 + int'(r[1:0]));
      else issue(r[2:0], r[18:3], $urandom, $urandom, $urandom);
    end
    idle(2);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule